// File: doc/BRIEF.md
# Boot-Time Port Pin Role Controller

This block decides what four multiplexed pins of a general-purpose I/O port do, from the end of reset until software owns them. The pins are numbered 0 to 3 inside the block. They map to port bits 4 to 7: sleep-interrupt (0), byte-high-enable (1), ready (2) and bus-width (3). Every pin comes out of reset with only its weak pull-high enabled.

Two events release the pins. The first is a configuration-fetch-done strobe, which carries the chip configuration word. The second is the first write to the port mode register. The configuration bits are captured once, on the first strobe after reset. They alone decide two things: whether pin 1 becomes the byte-high-enable system output, and whether pin 2 becomes the system ready input. The mode register and the output data register are loaded together through one write port.

A small state machine tracks which events have happened. Its states are ST_RESET (no event yet), ST_MODE_SET (mode written, no fetch yet), ST_CFG_SET (fetch done, no mode write yet) and ST_SETTLED (both events seen). The transitions are:

- ST_RESET goes to ST_MODE_SET on a mode write.
- ST_RESET goes to ST_CFG_SET on the strobe.
- ST_RESET goes to ST_SETTLED when both arrive in the same cycle.
- ST_MODE_SET goes to ST_SETTLED on the strobe.
- ST_CFG_SET goes to ST_SETTLED on a mode write.
- ST_SETTLED is final until reset.

The pin outputs are decoded without extra registers from this state, the captured configuration and the two port registers. They therefore change in the cycle after the clock edge that takes the event.

Top module: `pinctl_top`

## Requirements
- R1: After reset: pull_en is 4'b1111, drive_en is 4'b0000, bus_ready is 1 and lock_hazard is 0. The mode register resets to 4'b0000 and the data register to 4'b1111.
- R2: Pins 0 and 3 keep pull_en high until the first mode write, whether or not the fetch has happened. After that write, pull_en is low. A pin whose mode bit is 0 is driven push-pull with its data bit. A pin whose mode bit is 1 is neither pulled nor driven.
- R3: Pin 1 keeps pull_en high until the fetch completes, even if a mode write came first.
- R4: If the bus-width bit captured at the fetch is 1, pin 1 is driven push-pull with bhe_n_in from the fetch onward, whatever the mode register holds.
- R5: If the captured bus-width bit is 0, pin 1 keeps pull_en high until both the fetch and the first mode write have happened. It is then driven with its data bit when mode bit 1 is 0, and with bhe_n_in when mode bit 1 is 1.
- R6: Pin 2 keeps pull_en high until the fetch completes and has it low afterwards.
- R7: If the captured wait-control field is all ones, pin 2 is the system ready input: it is not driven, and bus_ready follows pad_in[2]. For any other value, bus_ready is 1, and after the fetch pin 2 is driven with its data bit when mode bit 2 is 0 and left undriven when it is 1.
- R8: lock_hazard is 1 exactly when the fetch has selected the system ready input and mode bit 2 is 0.
- R9: Only the first strobe after reset captures the configuration. Later strobes and all mode writes leave the captured values unchanged.
- R10: For no pin are pull_en and drive_en high in the same cycle.
- R11: The strobe and the first mode write may arrive in either order or in the same cycle. The outputs then equal those for the same events taken one at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_done | input | 1 | Configuration fetch complete strobe |
| cfg_wide_bus | input | 1 | Fetched bus-width bit, valid with cfg_done |
| cfg_wait_ctl | input | WAIT_W | Fetched wait-control field, valid with cfg_done |
| mode_wr | input | 1 | Port mode/data register write strobe |
| wr_mode | input | 4 | Mode bits, bit i for pin i |
| wr_data | input | 4 | Output data bits, bit i for pin i |
| bhe_n_in | input | 1 | Byte-high-enable value from the bus logic |
| pad_in | input | 4 | Pin input levels |
| pull_en | output | 4 | Weak pull-high enable per pin |
| drive_en | output | 4 | Strong push-pull drive enable per pin |
| drive_val | output | 4 | Driven level per pin, 0 when not driven |
| bus_ready | output | 1 | Ready signal presented to the bus logic |
| lock_hazard | output | 1 | System ready selected while mode bit 2 is clear |

## Verification
Every combination of the bus-width bit and the eight wait-control codes is tried with the fetch first, the mode write first, and both in the same cycle. This separates the pins released by the fetch from those released by software, and it shows whether a simultaneous arrival is handled like the two orders. After each scenario settles, all sixteen mode values are written with complementary data, each with both levels of bhe_n_in and pad_in. This tells the push-pull data path apart from the system-function path, exposes the hazard flag for every code, and shows whether bus_ready is forced. A second strobe carrying inverted configuration confirms that the captured values do not move.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    typedef enum logic [1:0] {
        ST_RESET    = 2'd0,
        ST_MODE_SET = 2'd1,
        ST_CFG_SET  = 2'd2,
        ST_SETTLED  = 2'd3
    } boot_state_t;

    typedef enum logic [1:0] {
        ROLE_SLEEP = 2'd0,
        ROLE_BHE   = 2'd1,
        ROLE_READY = 2'd2,
        ROLE_WIDTH = 2'd3
    } pin_role_t;

    localparam int unsigned NUM_PINS = 4;

endpackage

// File: rtl/pinctl_seq.sv
module pinctl_seq
    import pinctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_done,
    input  logic mode_wr,
    output logic fetched,
    output logic written,
    output logic take_cfg
);

    boot_state_t state_q;
    boot_state_t state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RESET: begin
                if (cfg_done && mode_wr) begin
                    state_d = ST_SETTLED;
                end else if (cfg_done) begin
                    state_d = ST_CFG_SET;
                end else if (mode_wr) begin
                    state_d = ST_MODE_SET;
                end
            end
            ST_MODE_SET: begin
                if (cfg_done) begin
                    state_d = ST_SETTLED;
                end
            end
            ST_CFG_SET: begin
                if (mode_wr) begin
                    state_d = ST_SETTLED;
                end
            end
            ST_SETTLED: begin
                state_d = ST_SETTLED;
            end
            default: begin
                state_d = ST_RESET;
            end
        endcase
    end

    always_comb begin
        fetched  = 1'b0;
        written  = 1'b0;
        unique case (state_q)
            ST_RESET:    begin fetched = 1'b0; written = 1'b0; end
            ST_MODE_SET: begin fetched = 1'b0; written = 1'b1; end
            ST_CFG_SET:  begin fetched = 1'b1; written = 1'b0; end
            ST_SETTLED:  begin fetched = 1'b1; written = 1'b1; end
            default:     begin fetched = 1'b0; written = 1'b0; end
        endcase
        take_cfg = cfg_done && !fetched;
    end

endmodule

// File: rtl/pinctl_cfg_latch.sv
module pinctl_cfg_latch #(
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_cfg,
    input  logic              cfg_wide_bus,
    input  logic [WAIT_W-1:0] cfg_wait_ctl,
    output logic              wide_q,
    output logic              sys_ready_q
);

    localparam logic [WAIT_W-1:0] READY_CODE = {WAIT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q      <= 1'b0;
            sys_ready_q <= 1'b0;
        end else if (take_cfg) begin
            wide_q      <= cfg_wide_bus;
            sys_ready_q <= (cfg_wait_ctl == READY_CODE);
        end
    end

endmodule

// File: rtl/pinctl_pin_drv.sv
module pinctl_pin_drv
    import pinctl_pkg::*;
#(
    parameter pin_role_t ROLE = ROLE_SLEEP
) (
    input  logic fetched,
    input  logic written,
    input  logic wide_q,
    input  logic sys_ready_q,
    input  logic mode_bit,
    input  logic data_bit,
    input  logic bhe_n_in,
    output logic pull,
    output logic drive,
    output logic val
);

    always_comb begin
        pull  = 1'b0;
        drive = 1'b0;
        val   = 1'b0;
        unique case (ROLE)
            ROLE_SLEEP, ROLE_WIDTH: begin
                // released only by software
                pull  = !written;
                drive = written && !mode_bit;
                val   = drive && data_bit;
            end
            ROLE_BHE: begin
                if (!fetched) begin
                    pull = 1'b1;
                end else if (wide_q) begin
                    drive = 1'b1;
                    val   = bhe_n_in;
                end else if (!written) begin
                    pull = 1'b1;
                end else begin
                    drive = 1'b1;
                    val   = mode_bit ? bhe_n_in : data_bit;
                end
            end
            ROLE_READY: begin
                if (!fetched) begin
                    pull = 1'b1;
                end else if (!sys_ready_q && !mode_bit) begin
                    drive = 1'b1;
                    val   = data_bit;
                end
            end
            default: begin
                pull = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/pinctl_top.sv
module pinctl_top
    import pinctl_pkg::*;
#(
    parameter int unsigned WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic              cfg_wide_bus,
    input  logic [WAIT_W-1:0] cfg_wait_ctl,
    input  logic              mode_wr,
    input  logic [3:0]        wr_mode,
    input  logic [3:0]        wr_data,
    input  logic              bhe_n_in,
    input  logic [3:0]        pad_in,
    output logic [3:0]        pull_en,
    output logic [3:0]        drive_en,
    output logic [3:0]        drive_val,
    output logic              bus_ready,
    output logic              lock_hazard
);

    localparam int unsigned READY_IDX = 2;

    logic       fetched;
    logic       written;
    logic       take_cfg;
    logic       wide_q;
    logic       sys_ready_q;
    logic [3:0] mode_q;
    logic [3:0] data_q;

    pinctl_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_done (cfg_done),
        .mode_wr  (mode_wr),
        .fetched  (fetched),
        .written  (written),
        .take_cfg (take_cfg)
    );

    pinctl_cfg_latch #(.WAIT_W(WAIT_W)) u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .take_cfg     (take_cfg),
        .cfg_wide_bus (cfg_wide_bus),
        .cfg_wait_ctl (cfg_wait_ctl),
        .wide_q       (wide_q),
        .sys_ready_q  (sys_ready_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 4'b0000;
            data_q <= 4'b1111;
        end else if (mode_wr) begin
            mode_q <= wr_mode;
            data_q <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam pin_role_t PIN_ROLE = pin_role_t'(p);
        pinctl_pin_drv #(.ROLE(PIN_ROLE)) u_drv (
            .fetched     (fetched),
            .written     (written),
            .wide_q      (wide_q),
            .sys_ready_q (sys_ready_q),
            .mode_bit    (mode_q[p]),
            .data_bit    (data_q[p]),
            .bhe_n_in    (bhe_n_in),
            .pull        (pull_en[p]),
            .drive       (drive_en[p]),
            .val         (drive_val[p])
        );
    end

    assign bus_ready   = sys_ready_q ? pad_in[READY_IDX] : 1'b1;
    assign lock_hazard = fetched && sys_ready_q && !mode_q[READY_IDX];

endmodule

// File: rtl/pinctl_checker.sv
module pinctl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_done,
    input logic       mode_wr,
    input logic       bhe_n_in,
    input logic [3:0] pull_en,
    input logic [3:0] drive_en,
    input logic [3:0] drive_val,
    input logic       bus_ready,
    input logic       lock_hazard,
    input logic       fetched,
    input logic       wide_q,
    input logic       sys_ready_q
);

    assert_no_contention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en & drive_en) == 4'b0000);

    assert_sleep_pull_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en[0] && !mode_wr) |=> pull_en[0]);

    assert_sleep_pull_gone_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pull_en[0] |=> !pull_en[0]);

    assert_ready_pull_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_en[2] && !cfg_done) |=> pull_en[2]);

    assert_ready_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_ready_q |-> bus_ready);

    assert_hazard_pin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lock_hazard |-> (!drive_en[2] && !pull_en[2]));

    assert_wide_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetched && wide_q) |-> (drive_en[1] && drive_val[1] == bhe_n_in));

    assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fetched |=> ($stable(wide_q) && $stable(sys_ready_q)));

endmodule

bind pinctl_top pinctl_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_done    (cfg_done),
    .mode_wr     (mode_wr),
    .bhe_n_in    (bhe_n_in),
    .pull_en     (pull_en),
    .drive_en    (drive_en),
    .drive_val   (drive_val),
    .bus_ready   (bus_ready),
    .lock_hazard (lock_hazard),
    .fetched     (fetched),
    .wide_q      (wide_q),
    .sys_ready_q (sys_ready_q)
);

// File: tb/pinctl_top_tb.sv
`timescale 1ns/1ps
module pinctl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_done = 1'b0;
    logic       cfg_wide_bus = 1'b0;
    logic [2:0] cfg_wait_ctl = 3'd0;
    logic       mode_wr = 1'b0;
    logic [3:0] wr_mode = 4'd0;
    logic [3:0] wr_data = 4'd0;
    logic       bhe_n_in = 1'b0;
    logic [3:0] pad_in = 4'd0;
    logic [3:0] pull_en;
    logic [3:0] drive_en;
    logic [3:0] drive_val;
    logic       bus_ready;
    logic       lock_hazard;

    int n_checks = 0;
    int n_fail = 0;

    // reference state, kept from the requirements
    bit       m_fetched, m_written, m_wide, m_sysrdy;
    bit [3:0] m_mode, m_data;

    always #5 clk = ~clk;

    pinctl_top #(.WAIT_W(3)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_done     (cfg_done),
        .cfg_wide_bus (cfg_wide_bus),
        .cfg_wait_ctl (cfg_wait_ctl),
        .mode_wr      (mode_wr),
        .wr_mode      (wr_mode),
        .wr_data      (wr_data),
        .bhe_n_in     (bhe_n_in),
        .pad_in       (pad_in),
        .pull_en      (pull_en),
        .drive_en     (drive_en),
        .drive_val    (drive_val),
        .bus_ready    (bus_ready),
        .lock_hazard  (lock_hazard)
    );

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string ctx);
        bit [3:0] ep, ed, ev;
        bit       er, eh;
        for (int k = 0; k < 2; k++) begin
            bhe_n_in = k[0];
            pad_in   = k[0] ? 4'b1011 : 4'b0100;
            #1;
            ep = '0; ed = '0; ev = '0;
            // R2: pins 0 and 3
            for (int p = 0; p < 4; p += 3) begin
                ep[p] = !m_written;
                ed[p] = m_written && !m_mode[p];
                ev[p] = ed[p] && m_data[p];
            end
            // R3 R4 R5: pin 1
            if (!m_fetched) ep[1] = 1'b1;
            else if (m_wide) begin ed[1] = 1'b1; ev[1] = bhe_n_in; end
            else if (!m_written) ep[1] = 1'b1;
            else begin ed[1] = 1'b1; ev[1] = m_mode[1] ? bhe_n_in : m_data[1]; end
            // R6 R7: pin 2
            if (!m_fetched) ep[2] = 1'b1;
            else if (!m_sysrdy && !m_mode[2]) begin ed[2] = 1'b1; ev[2] = m_data[2]; end
            er = m_sysrdy ? pad_in[2] : 1'b1;
            eh = m_fetched && m_sysrdy && !m_mode[2];
            check({"R2 R3 R5 R6 pull ", ctx}, pull_en, ep);
            check({"R2 R4 R5 R7 drive ", ctx}, drive_en, ed);
            check({"R2 R4 R5 value ", ctx}, drive_val, ev);
            check({"R7 bus_ready ", ctx}, {3'b0, bus_ready}, {3'b0, er});
            check({"R8 lock_hazard ", ctx}, {3'b0, lock_hazard}, {3'b0, eh});
            check({"R10 contention ", ctx}, pull_en & drive_en, 4'b0000);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cfg_done = 1'b0;
        mode_wr = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        m_fetched = 0; m_written = 0; m_wide = 0; m_sysrdy = 0;
        m_mode = 4'b0000; m_data = 4'b1111;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
        $finish;
    end

    initial begin
        bit [3:0] pm;
        #2;
        for (int w = 0; w < 2; w++) begin
            for (int c = 0; c < 8; c++) begin
                for (int ord = 0; ord < 3; ord++) begin
                    do_reset();
                    check_all("R1 reset");
                    check("R1 reset pull", pull_en, 4'b1111);
                    pm = {c[0], w[0], c[2], c[1]};
                    cfg_wide_bus = w[0];
                    cfg_wait_ctl = c[2:0];
                    wr_mode = pm;
                    wr_data = ~pm ^ {c[1:0], c[1:0]};
                    // R11 orderings
                    if (ord == 0 || ord == 2) cfg_done = 1'b1;
                    if (ord == 1 || ord == 2) mode_wr = 1'b1;
                    tick();
                    if (cfg_done) begin m_fetched = 1; m_wide = w[0]; m_sysrdy = (c == 7); end
                    if (mode_wr) begin m_written = 1; m_mode = wr_mode; m_data = wr_data; end
                    cfg_done = 1'b0; mode_wr = 1'b0;
                    check_all("R11 first event");
                    tick();
                    check_all("R11 idle hold");
                    if (ord == 0) begin
                        mode_wr = 1'b1; tick(); mode_wr = 1'b0;
                        m_written = 1; m_mode = wr_mode; m_data = wr_data;
                    end else if (ord == 1) begin
                        cfg_done = 1'b1; tick(); cfg_done = 1'b0;
                        m_fetched = 1; m_wide = w[0]; m_sysrdy = (c == 7);
                    end
                    check_all("R11 second event");
                    // R9: second strobe with inverted configuration
                    cfg_wide_bus = ~w[0];
                    cfg_wait_ctl = ~c[2:0];
                    cfg_done = 1'b1; tick(); cfg_done = 1'b0;
                    check_all("R9 late strobe");
                    for (int m = 0; m < 16; m++) begin
                        wr_mode = m[3:0];
                        wr_data = ~m[3:0];
                        mode_wr = 1'b1; tick(); mode_wr = 1'b0;
                        m_mode = m[3:0]; m_data = ~m[3:0];
                        check_all("R9 mode sweep");
                    end
                end
            end
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule